// File: doc/BRIEF.md
# Modem Control and Automatic Clear-to-Send Gate

This block holds the modem control register of a 16550-style serial port and samples the four modem status inputs. Four control bits drive the active-low outputs for terminal-ready, request-to-send and two general-purpose lines. The status inputs are clear-to-send, data-set-ready, ring and carrier. Each one passes through a synchroniser. Its inverted level is reported in the upper half of the status byte. The lower half holds sticky change flags, and a single read clears all of them. When any change flag is set, the modem-status-change output goes high for the interrupt logic.

Characters travel from the holding stage to the transmit shifter over a valid/ready stream that passes through this block. Automatic hardware flow control can be enabled. While it is enabled and clear-to-send is inactive, the block withholds both valid and ready, so no new character is handed over. A character the shifter has already accepted is unaffected, so it finishes on the line. When flow control is disabled, clear-to-send has no effect on the stream. Data-set-ready and terminal-ready never affect it.

Top module: `mdm_ctrl_top`

## Requirements
- R1: While `rst` is high, `dtr_n`, `rts_n`, `op1_n` and `op2_n` are 1, `mcr_rdata` is 0 and all change flags (`msr_rdata[3:0]`) are 0.
- R2: A write (`mcr_we` high at a clock edge) takes effect at that edge. `dtr_n` becomes the inverse of data bit 0 and `rts_n` becomes the inverse of data bit 1.
- R3: On the same write, `op1_n` becomes the inverse of bit 2 and `op2_n` the inverse of bit 3. `mcr_rdata` returns bits 3..0 as written, and bits 7..4 read as 0.
- R4: `msr_rdata` bit 4 is inverted CTS, bit 5 inverted DSR, bit 6 inverted RI and bit 7 inverted CD. Each follows its pin after the second rising edge.
- R5: Change flags bit 0 (CTS), bit 1 (DSR) and bit 3 (CD) set on the third edge after a change of that pin in either direction. They stay set until the status byte is read.
- R6: Flag bit 2 sets only when `ri_n` goes from 0 to 1. A 1-to-0 change of `ri_n` leaves the flag clear.
- R7: An edge with `msr_rd` high clears all change flags. A change event that lands on the same edge still sets its flag.
- R8: `msc_irq` is 1 exactly when any change flag is set.
- R9: With `auto_cts_en` low, `tx_out_valid` = `tx_in_valid` and `tx_in_ready` = `tx_out_ready`, whatever the levels of `cts_n` and `dsr_n`. `tx_out_data` always equals `tx_in_data`.
- R10: With `auto_cts_en` high and synchronised CTS inactive, `tx_allow`, `tx_out_valid` and `tx_in_ready` are 0. Passing resumes two edges after `cts_n` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mcr_we | input | 1 | Control register write strobe |
| mcr_wdata | input | 8 | Control register write data |
| mcr_rdata | output | 8 | Control register read value |
| msr_rd | input | 1 | Status read strobe; clears change flags |
| msr_rdata | output | 8 | Status byte: levels 7..4, change flags 3..0 |
| msc_irq | output | 1 | Modem status change flag |
| auto_cts_en | input | 1 | Enables automatic clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| cd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| op1_n | output | 1 | General-purpose output 1, active low |
| op2_n | output | 1 | General-purpose output 2, active low |
| tx_in_valid | input | 1 | Character offered by holding stage |
| tx_in_ready | output | 1 | Character accepted from holding stage |
| tx_in_data | input | 8 | Character from holding stage |
| tx_out_valid | output | 1 | Character offered to shifter |
| tx_out_ready | input | 1 | Shifter can start a new character |
| tx_out_data | output | 8 | Character to shifter |
| tx_allow | output | 1 | A new character may start |

## Verification
A status read and a new change event can fall on the same clock edge. The clear must then not swallow the event. The bench provokes this by dropping `cts_n` exactly three edges before a read strobe, so the flag-setting edge is also the reading edge. It then checks three things. The value read on that edge still shows the flag clear. After the edge the CTS change flag and `msc_irq` are set. A later read with no event clears them.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W    = 8;
  localparam int CTRL_W   = 4;
  localparam int NUM_MDM  = 4;
  // status input index, also the change-flag position
  localparam int IX_CTS = 0;
  localparam int IX_DSR = 1;
  localparam int IX_RI  = 2;
  localparam int IX_CD  = 3;
  // control bit positions
  localparam int CB_DTR = 0;
  localparam int CB_RTS = 1;
  localparam int CB_OP1 = 2;
  localparam int CB_OP2 = 3;
  typedef logic [NUM_MDM-1:0] mdm_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mdm_vec_t act,     // synchronised levels, 1 = asserted
  input  logic     rd,
  output mdm_vec_t delta,
  output logic     msc
);
  mdm_vec_t prev_q, delta_q, ev;

  always_comb begin
    ev         = act ^ prev_q;
    // ring flag: only when the ring indication ends
    ev[IX_RI]  = prev_q[IX_RI] & ~act[IX_RI];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= act;
      delta_q <= (rd ? '0 : delta_q) | ev;
    end
  end

  assign delta = delta_q;
  assign msc   = |delta_q;
endmodule

// File: rtl/mdm_txgate.sv
module mdm_txgate #(
  parameter int DW = 8
) (
  input  logic          en,
  input  logic          cts_act,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          allow
);
  assign allow     = ~en | cts_act;
  assign out_valid = in_valid & allow;
  assign in_ready  = out_ready & allow;
  assign out_data  = in_data;
endmodule

// File: rtl/mdm_ctrl_top.sv
module mdm_ctrl_top
  import mdm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mcr_we,
  input  logic [REG_W-1:0]  mcr_wdata,
  output logic [REG_W-1:0]  mcr_rdata,
  input  logic              msr_rd,
  output logic [REG_W-1:0]  msr_rdata,
  output logic              msc_irq,
  input  logic              auto_cts_en,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              cd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              op1_n,
  output logic              op2_n,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              tx_allow
);
  localparam int PAD_W = REG_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  mdm_vec_t          pins_n, sync_n, act, delta;

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (mcr_we) ctrl_q <= mcr_wdata[CTRL_W-1:0];
  end

  assign mcr_rdata = {{PAD_W{1'b0}}, ctrl_q};
  assign dtr_n     = ~ctrl_q[CB_DTR];
  assign rts_n     = ~ctrl_q[CB_RTS];
  assign op1_n     = ~ctrl_q[CB_OP1];
  assign op2_n     = ~ctrl_q[CB_OP2];

  always_comb begin
    pins_n         = '1;
    pins_n[IX_CTS] = cts_n;
    pins_n[IX_DSR] = dsr_n;
    pins_n[IX_RI]  = ri_n;
    pins_n[IX_CD]  = cd_n;
  end

  mdm_sync #(.W(NUM_MDM), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(pins_n), .q(sync_n)
  );

  assign act = ~sync_n;

  mdm_status u_status (
    .clk(clk), .rst(rst), .act(act), .rd(msr_rd),
    .delta(delta), .msc(msc_irq)
  );

  assign msr_rdata = {act[IX_CD], act[IX_RI], act[IX_DSR], act[IX_CTS], delta};

  mdm_txgate #(.DW(DATA_W)) u_gate (
    .en(auto_cts_en), .cts_act(act[IX_CTS]),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .allow(tx_allow)
  );
endmodule

// File: rtl/mdm_ctrl_chk.sv
module mdm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mcr_we,
  input logic [7:0] mcr_wdata,
  input logic       msr_rd,
  input logic [7:0] msr_rdata,
  input logic       msc_irq,
  input logic       auto_cts_en,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       op1_n,
  input logic       op2_n,
  input logic       tx_in_ready,
  input logic       tx_out_valid
);
  p_reset_outputs_r1: assert property (@(posedge clk)
    rst |=> (dtr_n && rts_n && op1_n && op2_n && msr_rdata[3:0] == 4'h0));

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
    mcr_we |=> (dtr_n == !$past(mcr_wdata[0]) && rts_n == !$past(mcr_wdata[1])));

  p_gp_write_r3: assert property (@(posedge clk) disable iff (rst)
    mcr_we |=> (op1_n == !$past(mcr_wdata[2]) && op2_n == !$past(mcr_wdata[3])));

  p_flags_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !msr_rd |=> ((msr_rdata[3:0] & $past(msr_rdata[3:0])) == $past(msr_rdata[3:0])));

  p_msc_flag_r8: assert property (@(posedge clk) disable iff (rst)
    msc_irq == (msr_rdata[3:0] != 4'h0));

  p_cts_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (auto_cts_en && !msr_rdata[4]) |-> (!tx_out_valid && !tx_in_ready));
endmodule

bind mdm_ctrl_top mdm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata),
  .msr_rd(msr_rd), .msr_rdata(msr_rdata), .msc_irq(msc_irq),
  .auto_cts_en(auto_cts_en), .dtr_n(dtr_n), .rts_n(rts_n),
  .op1_n(op1_n), .op2_n(op2_n), .tx_in_ready(tx_in_ready),
  .tx_out_valid(tx_out_valid)
);

// File: tb/test_mdm_ctrl_top.sv
`timescale 1ns/1ps
module test_mdm_ctrl_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mcr_we = 1'b0;
  logic [7:0] mcr_wdata = '0;
  logic [7:0] mcr_rdata;
  logic       msr_rd = 1'b0;
  logic [7:0] msr_rdata;
  logic       msc_irq;
  logic       auto_cts_en = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic       dtr_n, rts_n, op1_n, op2_n;
  logic       tx_in_valid = 1'b0, tx_in_ready, tx_out_valid, tx_out_ready = 1'b0, tx_allow;
  logic [7:0] tx_in_data = '0, tx_out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mdm_ctrl_top i_mdm_ctrl_top (
    .clk(clk), .rst(rst), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata), .mcr_rdata(mcr_rdata),
    .msr_rd(msr_rd), .msr_rdata(msr_rdata), .msc_irq(msc_irq), .auto_cts_en(auto_cts_en),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .op1_n(op1_n), .op2_n(op2_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .tx_allow(tx_allow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {cd_n, ri_n, dsr_n, cts_n} applied, then expected status byte
  localparam logic [11:0] VEC [6] = '{
    {4'b1110, 8'h11},   // CTS asserted: level + flag (R4, R5)
    {4'b1100, 8'h32},   // DSR asserted
    {4'b1000, 8'h70},   // ring starts: no ring flag (R6)
    {4'b1100, 8'h34},   // ring ends: ring flag (R6)
    {4'b0100, 8'hB8},   // CD asserted
    {4'b1111, 8'h0B}    // all released: CTS, DSR, CD flags
  };

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); mcr_we = 1'b1; mcr_wdata = v;
    @(negedge clk); mcr_we = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); msr_rd = 1'b1;
    @(negedge clk); msr_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 modem outputs", {dtr_n, rts_n, op1_n, op2_n}, 4'hF);
    chk("R1 ctrl readback", mcr_rdata, 8'h00);
    chk("R1 change flags", msr_rdata[3:0], 4'h0);
    @(negedge clk); rst = 1'b0;

    // table walk over status inputs
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      {cd_n, ri_n, dsr_n, cts_n} = VEC[i][11:8];
      repeat (3) @(posedge clk);
      #1;
      chk("R4 R5 R6 status byte", msr_rdata, VEC[i][7:0]);
      chk("R8 msc_irq", msc_irq, VEC[i][3:0] != 4'h0);
      do_read();
      chk("R7 read clears flags", msr_rdata[3:0], 4'h0);
    end

    // control register
    do_write(8'h01);
    #1;
    chk("R2 dtr only", {dtr_n, rts_n, op1_n, op2_n}, 4'b0111);
    do_write(8'h0E);
    chk("R2 R3 rts op1 op2", {dtr_n, rts_n, op1_n, op2_n}, 4'b1000);
    do_write(8'hF5);
    chk("R3 readback masks upper", mcr_rdata, 8'h05);
    chk("R3 outputs after F5", {dtr_n, rts_n, op1_n, op2_n}, 4'b0101);

    // read and flag set on the same edge (R7)
    @(negedge clk); cts_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 flag not yet set", msr_rdata[0], 1'b0);
    msr_rd = 1'b1;
    @(negedge clk); msr_rd = 1'b0;
    chk("R7 event wins over clear", msr_rdata[0], 1'b1);
    chk("R8 msc after collision", msc_irq, 1'b1);
    do_read();
    chk("R7 later read clears", msr_rdata[3:0], 4'h0);

    // stream gate, flow control off: CTS and DSR irrelevant (R9)
    @(negedge clk);
    tx_in_valid = 1'b1; tx_out_ready = 1'b1; tx_in_data = 8'hA5;
    cts_n = 1'b1; dsr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 pass with cts inactive", {tx_out_valid, tx_in_ready, tx_allow}, 3'b111);
    chk("R9 data passes", tx_out_data, 8'hA5);
    tx_out_ready = 1'b0;
    #1;
    chk("R9 backpressure", {tx_out_valid, tx_in_ready}, 2'b10);
    tx_out_ready = 1'b1;

    // flow control on, CTS inactive (R10)
    auto_cts_en = 1'b1;
    #1;
    chk("R10 blocked", {tx_out_valid, tx_in_ready, tx_allow}, 3'b000);
    @(negedge clk); cts_n = 1'b0;
    @(negedge clk);
    chk("R10 still blocked after one edge", tx_allow, 1'b0);
    @(negedge clk);
    chk("R10 resumes after two edges", {tx_out_valid, tx_in_ready, tx_allow}, 3'b111);
    @(negedge clk); dsr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 dsr has no effect", {tx_out_valid, tx_in_ready}, 2'b11);

    // reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again outputs", {dtr_n, rts_n, op1_n, op2_n}, 4'hF);
    chk("R1 reset again flags", msr_rdata[3:0], 4'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule